// File: doc/BRIEF.md
# Parallel Printer Port Host Register File

This block is the register file that a host processor sees for a legacy parallel printer port. It provides three byte-wide registers at offsets 0, 1 and 2 from a base address. Offset 0 holds the data byte for the port's data lines. Offset 1 reports the state of the port's status lines. Offset 2 sets the port's handshake and control lines. Between a register bit and its pin, some signals are inverted and some are not. The block applies that inversion in both directions, so software always works with the logical sense of each signal.

The block also detects rising edges of the acknowledge line. It synchronises that line and turns each rising edge into a single-cycle interrupt pulse when the interrupt enable is set. In enhanced-parallel-port mode, a transfer engine outside the block signals the start and the end of each bus cycle. A prescaled counter times each cycle and sets a sticky timeout flag if a cycle is still open after the timeout window. Software clears the flag by writing a one to it. A two-bit mode input selects standard, enhanced or extended-capability behaviour.

Top module: `pport_regs`

## Requirements
- R1: Offset 0 resets to 00h, stores any written byte, reads it back unchanged and drives it on `pdOut` from the clock edge of the write.
- R2: A read of offset 1 returns the inverted busy pin in bit 7 and the acknowledge, paper-end, select and error pins unchanged in bits 6, 5, 4 and 3.
- R3: Bits 2:1 of offset 1 and bits 7:6 of offset 2 always read as ones.
- R4: In EPP mode (`portMode` = 01), a cycle-start pulse arms a counter of TO = CLK_HZ/1e6 x TIMEOUT_US clocks. The timeout flag is set by the TO-th clock edge after the arming edge unless cycle-done is seen at or before that edge. A cycle-start pulse in any other mode arms nothing.
- R5: Writing offset 1 with bit 0 = 1 clears the timeout flag, and writing it with bit 0 = 0 leaves the flag unchanged. The flag stays set until cleared. A timeout and a clear on the same edge leave the flag set.
- R6: In any mode other than EPP (codes 00 SPP, 10 and 11 ECP), bit 0 of offset 1 reads as 1. In EPP mode it reads the timeout flag.
- R7: Offset 2 bits 3, 2, 1 and 0 drive `slinNPin` inverted, `initNPin` direct, `afdNPin` inverted and `strobeNPin` inverted. A read returns each pin with the same polarity. Every control bit resets to 0.
- R8: Offset 2 bit 5 is the direction bit (0 output, 1 input) and appears on `dirOut`. It resets to 0, and in SPP mode both the read value and `dirOut` are forced to 1.
- R9: When offset 2 bit 4 is set, each rising edge of `ackNPin` gives one single-cycle `ackIrq` pulse, two clock edges after the pin change. When the bit is clear, or on a falling edge, no pulse is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 2 | Register offset |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for busAddr (combinational) |
| portMode | input | 2 | 00 SPP, 01 EPP, 10/11 ECP |
| eppCycleStart | input | 1 | EPP cycle begins, arms the timeout |
| eppCycleDone | input | 1 | EPP cycle completed, stops the timeout |
| busyPin | input | 1 | BUSY line |
| ackNPin | input | 1 | Acknowledge line, active low |
| pePin | input | 1 | Paper-end line |
| slctPin | input | 1 | Select line |
| errNPin | input | 1 | Error line, active low |
| pdOut | output | 8 | Port data lines |
| strobeNPin | output | 1 | Strobe line, active low |
| afdNPin | output | 1 | Auto-feed line, active low |
| initNPin | output | 1 | Initialise line, active low |
| slinNPin | output | 1 | Select-in line, active low |
| dirOut | output | 1 | Data direction, 1 = input |
| ackIrq | output | 1 | Acknowledge interrupt pulse |

## Verification
Two events can meet on one clock edge. The first pair is timeout expiry and a software write that clears the flag. The second pair is expiry and the cycle-done report. The bench arms a cycle and counts clock edges from the arming edge. It then places either the clear write or the done pulse on exactly the TO-th edge. The rule is that a flag set by expiry survives a clear on the same edge, while a cycle reported done on that edge never sets the flag. The bench reads the status register one edge later to judge each case.

// File: rtl/pport_pkg.sv
package pport_pkg;

  typedef enum logic [1:0] {
    MODE_SPP  = 2'b00,
    MODE_EPP  = 2'b01,
    MODE_ECP  = 2'b10,
    MODE_ECP2 = 2'b11
  } portMode_e;

  localparam logic [1:0] OFS_DATA = 2'd0;
  localparam logic [1:0] OFS_STAT = 2'd1;
  localparam logic [1:0] OFS_CTRL = 2'd2;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrData;
    logic wrCtrl;
    logic clrTmo;
    logic setTmo;
    logic ackRise;
  } regStrobes_t;

endpackage

// File: rtl/pport_ctrl.sv
module pport_ctrl
  import pport_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 50_000_000,
  parameter int unsigned TIMEOUT_US  = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  busAddr,
  input  logic        busWrEn,
  input  logic        busWbit0,
  input  logic [1:0]  portMode,
  input  logic        eppCycleStart,
  input  logic        eppCycleDone,
  input  logic        ackNPin,
  output regStrobes_t strobes
);

  localparam int unsigned TO_CYCLES = (CLK_HZ / 1_000_000) * TIMEOUT_US;
  localparam int unsigned CW        = $clog2(TO_CYCLES + 1);

  logic          isEpp;
  logic          armNow;
  logic          toRun;
  logic [CW-1:0] toCnt;
  logic          expire;

  assign isEpp  = (portMode == MODE_EPP);
  assign armNow = eppCycleStart && isEpp;
  assign expire = toRun && !eppCycleDone && !armNow && (toCnt == CW'(TO_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      toRun <= 1'b0;
      toCnt <= '0;
    end else if (armNow) begin
      toRun <= 1'b1;
      toCnt <= '0;
    end else if (toRun) begin
      if (eppCycleDone || expire) begin
        toRun <= 1'b0;
        toCnt <= '0;
      end else begin
        toCnt <= toCnt + 1'b1;
      end
    end
  end

  // Acknowledge synchroniser plus one edge-detect stage
  logic [SYNC_STAGES:0] ackPipe;

  always_ff @(posedge clk) begin
    if (!rstN) ackPipe <= '1;
    else       ackPipe <= {ackPipe[SYNC_STAGES-1:0], ackNPin};
  end

  always_comb begin
    strobes.wrData  = busWrEn && (busAddr == OFS_DATA);
    strobes.wrCtrl  = busWrEn && (busAddr == OFS_CTRL);
    strobes.clrTmo  = busWrEn && (busAddr == OFS_STAT) && busWbit0;
    strobes.setTmo  = expire;
    strobes.ackRise = ackPipe[SYNC_STAGES-1] && !ackPipe[SYNC_STAGES];
  end

  // R4
  run_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    toRun |-> (toCnt < CW'(TO_CYCLES)));

  // R4
  done_stops_chk: assert property (@(posedge clk) disable iff (!rstN)
    (toRun && eppCycleDone && !armNow) |=> !toRun);

  // R9
  ack_rise_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.ackRise |=> !strobes.ackRise);

endmodule

// File: rtl/pport_dpath.sv
module pport_dpath
  import pport_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  regStrobes_t strobes,
  input  logic [1:0]  busAddr,
  input  logic [7:0]  busWdata,
  input  logic [1:0]  portMode,
  input  logic        busyPin,
  input  logic        ackNPin,
  input  logic        pePin,
  input  logic        slctPin,
  input  logic        errNPin,
  output logic [7:0]  busRdata,
  output logic [7:0]  pdOut,
  output logic        strobeNPin,
  output logic        afdNPin,
  output logic        initNPin,
  output logic        slinNPin,
  output logic        dirOut,
  output logic        ackIrq
);

  logic [7:0] dataReg;
  logic       dirReg;
  logic       irqEn;
  logic       slinBit;
  logic       initBit;
  logic       afdBit;
  logic       stbBit;
  logic       tmoFlag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReg <= 8'h00;
    end else if (strobes.wrData) begin
      dataReg <= busWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirReg  <= 1'b0;
      irqEn   <= 1'b0;
      slinBit <= 1'b0;
      initBit <= 1'b0;
      afdBit  <= 1'b0;
      stbBit  <= 1'b0;
    end else if (strobes.wrCtrl) begin
      dirReg  <= busWdata[5];
      irqEn   <= busWdata[4];
      slinBit <= busWdata[3];
      initBit <= busWdata[2];
      afdBit  <= busWdata[1];
      stbBit  <= busWdata[0];
    end
  end

  // Expiry wins over a clear on the same edge
  always_ff @(posedge clk) begin
    if (!rstN)               tmoFlag <= 1'b0;
    else if (strobes.setTmo) tmoFlag <= 1'b1;
    else if (strobes.clrTmo) tmoFlag <= 1'b0;
  end

  logic sppMode;
  logic eppMode;
  assign sppMode = (portMode == MODE_SPP);
  assign eppMode = (portMode == MODE_EPP);

  assign pdOut      = dataReg;
  assign slinNPin   = ~slinBit;
  assign initNPin   = initBit;
  assign afdNPin    = ~afdBit;
  assign strobeNPin = ~stbBit;
  assign dirOut     = dirReg | sppMode;
  assign ackIrq     = strobes.ackRise & irqEn;

  logic [7:0] statByte;
  logic [7:0] ctrlByte;

  always_comb begin
    statByte = {~busyPin, ackNPin, pePin, slctPin, errNPin, 2'b11,
                (eppMode ? tmoFlag : 1'b1)};
    ctrlByte = {2'b11, dirOut, irqEn, ~slinNPin, initNPin, ~afdNPin, ~strobeNPin};
    case (busAddr)
      OFS_DATA: busRdata = dataReg;
      OFS_STAT: busRdata = statByte;
      OFS_CTRL: busRdata = ctrlByte;
      default:  busRdata = 8'h00;
    endcase
  end

  // R1
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.wrData |=> $stable(dataReg));

  // R5
  tmo_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.setTmo |=> tmoFlag);

  // R5
  tmo_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clrTmo && !strobes.setTmo) |=> !tmoFlag);

  // R5
  tmo_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tmoFlag && !strobes.clrTmo) |=> tmoFlag);

  // R9
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackIrq |=> !ackIrq);

endmodule

// File: rtl/pport_regs.sv
module pport_regs
  import pport_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 50_000_000,
  parameter int unsigned TIMEOUT_US = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] busAddr,
  input  logic       busWrEn,
  input  logic [7:0] busWdata,
  output logic [7:0] busRdata,
  input  logic [1:0] portMode,
  input  logic       eppCycleStart,
  input  logic       eppCycleDone,
  input  logic       busyPin,
  input  logic       ackNPin,
  input  logic       pePin,
  input  logic       slctPin,
  input  logic       errNPin,
  output logic [7:0] pdOut,
  output logic       strobeNPin,
  output logic       afdNPin,
  output logic       initNPin,
  output logic       slinNPin,
  output logic       dirOut,
  output logic       ackIrq
);

  regStrobes_t strobes;

  pport_ctrl #(
    .CLK_HZ     (CLK_HZ),
    .TIMEOUT_US (TIMEOUT_US),
    .SYNC_STAGES(2)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .busAddr      (busAddr),
    .busWrEn      (busWrEn),
    .busWbit0     (busWdata[0]),
    .portMode     (portMode),
    .eppCycleStart(eppCycleStart),
    .eppCycleDone (eppCycleDone),
    .ackNPin      (ackNPin),
    .strobes      (strobes)
  );

  pport_dpath u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .busAddr   (busAddr),
    .busWdata  (busWdata),
    .portMode  (portMode),
    .busyPin   (busyPin),
    .ackNPin   (ackNPin),
    .pePin     (pePin),
    .slctPin   (slctPin),
    .errNPin   (errNPin),
    .busRdata  (busRdata),
    .pdOut     (pdOut),
    .strobeNPin(strobeNPin),
    .afdNPin   (afdNPin),
    .initNPin  (initNPin),
    .slinNPin  (slinNPin),
    .dirOut    (dirOut),
    .ackIrq    (ackIrq)
  );

endmodule

// File: tb/pport_regs_tb.sv
module pport_regs_tb;

  localparam int unsigned TB_CLK_HZ = 50_000_000;
  localparam int unsigned TB_TO_US  = 1;
  localparam int unsigned TO        = (TB_CLK_HZ / 1_000_000) * TB_TO_US;

  logic       clk = 1'b0;
  logic       rstN;
  logic [1:0] busAddr;
  logic       busWrEn;
  logic [7:0] busWdata;
  logic [7:0] busRdata;
  logic [1:0] portMode;
  logic       eppCycleStart, eppCycleDone;
  logic       busyPin, ackNPin, pePin, slctPin, errNPin;
  logic [7:0] pdOut;
  logic       strobeNPin, afdNPin, initNPin, slinNPin, dirOut, ackIrq;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pport_regs #(.CLK_HZ(TB_CLK_HZ), .TIMEOUT_US(TB_TO_US)) u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWdata(busWdata), .busRdata(busRdata), .portMode(portMode),
    .eppCycleStart(eppCycleStart), .eppCycleDone(eppCycleDone),
    .busyPin(busyPin), .ackNPin(ackNPin), .pePin(pePin), .slctPin(slctPin),
    .errNPin(errNPin), .pdOut(pdOut), .strobeNPin(strobeNPin),
    .afdNPin(afdNPin), .initNPin(initNPin), .slinNPin(slinNPin),
    .dirOut(dirOut), .ackIrq(ackIrq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [7:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic armCycle();
    @(negedge clk);
    eppCycleStart = 1'b1;
    @(posedge clk);
    @(negedge clk);
    eppCycleStart = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      nErrors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic [7:0] expv;
    rstN = 1'b0; busAddr = 2'd0; busWrEn = 1'b0; busWdata = 8'h00;
    portMode = 2'b01; eppCycleStart = 1'b0; eppCycleDone = 1'b0;
    busyPin = 1'b0; ackNPin = 1'b1; pePin = 1'b0; slctPin = 1'b0; errNPin = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // Reset state: R1 R7 R8 R6
    readReg(2'd0, rd); check("R1 reset data", rd, 8'h00);
    check("R1 reset pdOut", pdOut, 8'h00);
    readReg(2'd2, rd); check("R7 reset ctrl read", rd, 8'hC0);
    check("R7 reset pins", {4'h0, slinNPin, initNPin, afdNPin, strobeNPin}, 8'h0B);
    check("R8 reset dirOut", {7'h0, dirOut}, 8'h00);
    readReg(2'd1, rd); check("R6 reset tmo in EPP", {7'h0, rd[0]}, 8'h00);

    // R1 sweep
    for (int v = 0; v < 256; v++) begin
      writeReg(2'd0, 8'(v));
      readReg(2'd0, rd); check("R1 data readback", rd, 8'(v));
      check("R1 data pins", pdOut, 8'(v));
    end

    // R7 R8 R3 sweep over modes
    for (int m = 0; m < 3; m++) begin
      portMode = 2'(m);
      for (int v = 0; v < 256; v++) begin
        logic dirE;
        writeReg(2'd2, 8'(v));
        dirE = v[5] | (m == 0);
        expv = {2'b11, dirE, 5'(v)};
        readReg(2'd2, rd); check("R7 R8 R3 ctrl read", rd, expv);
        check("R7 pin polarity", {4'h0, slinNPin, initNPin, afdNPin, strobeNPin},
              {4'h0, ~v[3], v[2], ~v[1], ~v[0]});
        check("R8 dirOut", {7'h0, dirOut}, {7'h0, dirE});
      end
    end
    writeReg(2'd2, 8'h00);

    // R2 R3 R6 status sweep (flag clear)
    for (int m = 0; m < 4; m++) begin
      portMode = 2'(m);
      for (int p = 0; p < 32; p++) begin
        @(negedge clk);
        {busyPin, ackNPin, pePin, slctPin, errNPin} = 5'(p);
        expv = {~p[4], p[3], p[2], p[1], p[0], 2'b11, (m != 1)};
        readReg(2'd1, rd); check("R2 R3 R6 status read", rd, expv);
      end
    end
    @(negedge clk);
    {busyPin, ackNPin, pePin, slctPin, errNPin} = 5'b01101;
    portMode = 2'b01;
    repeat (4) @(negedge clk);

    // R4 plain expiry
    armCycle();
    repeat (TO - 1) @(posedge clk);
    @(negedge clk);
    readReg(2'd1, rd); check("R4 no flag before TO", {7'h0, rd[0]}, 8'h00);
    @(posedge clk); @(negedge clk);
    readReg(2'd1, rd); check("R4 flag at TO", {7'h0, rd[0]}, 8'h01);
    // R6: reads 1 in other modes regardless
    portMode = 2'b00; readReg(2'd1, rd); check("R6 SPP tmo", {7'h0, rd[0]}, 8'h01);
    portMode = 2'b01;
    // R5: write 0 has no effect, write 1 clears
    writeReg(2'd1, 8'hFE);
    readReg(2'd1, rd); check("R5 write0 keeps", {7'h0, rd[0]}, 8'h01);
    writeReg(2'd1, 8'h01);
    readReg(2'd1, rd); check("R5 write1 clears", {7'h0, rd[0]}, 8'h00);

    // R5 clear and expiry on same edge
    armCycle();
    repeat (TO - 1) @(posedge clk);
    @(negedge clk);
    busAddr = 2'd1; busWdata = 8'h01; busWrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    busWrEn = 1'b0;
    readReg(2'd1, rd); check("R5 set wins over clear", {7'h0, rd[0]}, 8'h01);
    writeReg(2'd1, 8'h01);

    // R4 done on the expiry edge
    armCycle();
    repeat (TO - 1) @(posedge clk);
    @(negedge clk);
    eppCycleDone = 1'b1;
    @(posedge clk); @(negedge clk);
    eppCycleDone = 1'b0;
    repeat (5) @(negedge clk);
    readReg(2'd1, rd); check("R4 done at TO prevents", {7'h0, rd[0]}, 8'h00);

    // R4 start ignored outside EPP
    portMode = 2'b10;
    armCycle();
    repeat (TO + 5) @(negedge clk);
    portMode = 2'b01;
    readReg(2'd1, rd); check("R4 start ignored in ECP", {7'h0, rd[0]}, 8'h00);

    // R9 interrupt
    writeReg(2'd2, 8'h10);
    @(negedge clk); ackNPin = 1'b0;
    repeat (4) @(negedge clk);
    check("R9 no pulse on fall", {7'h0, ackIrq}, 8'h00);
    ackNPin = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R9 not yet", {7'h0, ackIrq}, 8'h00);
    @(posedge clk); @(negedge clk);
    check("R9 pulse", {7'h0, ackIrq}, 8'h01);
    @(posedge clk); @(negedge clk);
    check("R9 pulse ends", {7'h0, ackIrq}, 8'h00);
    writeReg(2'd2, 8'h00);
    @(negedge clk); ackNPin = 1'b0;
    repeat (4) @(negedge clk);
    ackNPin = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); @(negedge clk);
      check("R9 disabled no pulse", {7'h0, ackIrq}, 8'h00);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule